// File: doc/BRIEF.md
# Privilege-Gated Interrupt Pending Controller

This block records pending interrupt sources for seven interrupt classes. Each class has a 64-bit source vector and one bit in a per-class summary register. A source is posted or retired by giving its class code and a bit index. A single strobe wipes all state at once. The state is held in registers. From that state and three mode inputs (a hyperprivileged flag, a global interrupt-enable flag and an external trap-level-zero condition), combinational logic decides whether an interrupt must be taken and which class wins under a fixed priority.

The winning class depends on the privilege mode. In hyperprivileged mode only two classes can win, and both need the enable flag. In the lower mode the three highest classes ignore the enable flag and the other four need it. For the soft-interrupt class the block also produces a 4-bit level. A second class code selects one vector, which the block returns on a readback port.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Posting class t (code 0..6) at index i sets bit i of vector t and sets summary bit t, visible from the next clock edge. The class code 7 is ignored for post, clear and readback, and readback of code 7 returns zero.
- R2: Clearing class t at index i zeroes bit i of vector t. Summary bit t drops only when the whole vector t is zero after the clear.
- R3: A clear-all strobe zeroes every vector and the summary register at the next edge.
- R4: When a post and a clear name the same class and index in the same cycle, the bit ends up set. A clear-all strobe in the same cycle overrides both.
- R5: When the summary register is zero, the pending output is 0 and the class output is 7 (none), whatever the mode inputs.
- R6: With the hyperprivileged flag set, only class 1 (tick match) can win, and after it class 2 (interrupt vector). Either wins only while the enable flag is 1. All other classes are masked.
- R7: With the hyperprivileged flag clear, the class codes in falling priority are 0 trap-level-zero, 1 tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 soft interrupt and 6 resumable error. The highest eligible class is reported.
- R8: With the hyperprivileged flag clear, classes 0, 1 and 2 are eligible whatever the enable flag is. Classes 3 to 6 are eligible only while it is 1.
- R9: Class 0 is eligible only while its vector is nonzero and the trap-level-zero condition input is 1.
- R10: The soft level is taken from vector 5. If bit 0 or bit 16 is set it is 14. Otherwise it is the index of the highest set bit among bits 15 down to 1. If none of those bits is set it is 0.
- R11: The pending, class and level outputs follow the mode inputs and the registered state in the same cycle, with no register stage.
- R12: After reset all vectors are zero, pending is 0 and the class output is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| post_en | input | 1 | Post strobe |
| post_type | input | 3 | Class code to post |
| post_idx | input | 6 | Source index to post |
| clr_en | input | 1 | Clear strobe |
| clr_type | input | 3 | Class code to clear |
| clr_idx | input | 6 | Source index to clear |
| clr_all | input | 1 | Wipe all vectors and the summary |
| hpriv | input | 1 | Hyperprivileged mode flag |
| ie | input | 1 | Global interrupt enable |
| tlz_cond | input | 1 | Trap-level-zero condition |
| rd_type | input | 3 | Class code selected for readback |
| irq_pending | output | 1 | An interrupt must be taken |
| irq_type | output | 3 | Winning class code, 7 when none |
| soft_level | output | 4 | Soft-interrupt level |
| rd_vec | output | 64 | Vector of the class named by rd_type |

## Verification
The clocked checks assume that reset is applied before the first edge. They also assume that strobes, codes and mode flags settle between edges, so a post or clear seen at one edge shows up in the vectors after that edge. The bench changes every input only on the falling clock edge and samples one time unit later. It also drives the unused class code 7 on the strobes, so the checks cover it instead of just trusting that it is never used. The mode flags take every combination, both in directed phases and in a long random phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_TYPES = 7;
    localparam int TYPE_W    = 3;

    // codes in falling priority order for the lower privilege mode
    typedef enum logic [TYPE_W-1:0] {
        IT_TLZ    = 3'd0,
        IT_TICK   = 3'd1,
        IT_IVEC   = 3'd2,
        IT_CPUM   = 3'd3,
        IT_DEVM   = 3'd4,
        IT_SOFT   = 3'd5,
        IT_RESERR = 3'd6,
        IT_NONE   = 3'd7
    } irq_type_e;

    // classes that win in the lower mode whatever the enable flag is
    function automatic logic ignores_ie(input int t);
        return (t == int'(IT_TLZ)) || (t == int'(IT_TICK)) || (t == int'(IT_IVEC));
    endfunction

    // classes that may win in hyperprivileged mode
    function automatic logic hpriv_allowed(input int t);
        return (t == int'(IT_TICK)) || (t == int'(IT_IVEC));
    endfunction
endpackage

// File: rtl/irq_vec_store.sv
module irq_vec_store
    import irq_pkg::*;
#(
    parameter int N_TYPES = NUM_TYPES,
    parameter int VEC_W   = 64,
    localparam int IDX_W  = $clog2(VEC_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          post_en,
    input  logic [TYPE_W-1:0]             post_type,
    input  logic [IDX_W-1:0]              post_idx,
    input  logic                          clr_en,
    input  logic [TYPE_W-1:0]             clr_type,
    input  logic [IDX_W-1:0]              clr_idx,
    input  logic                          clr_all,
    output logic [N_TYPES-1:0][VEC_W-1:0] vec_o,
    output logic [N_TYPES-1:0]            sum_o
);
    typedef struct packed {
        logic [N_TYPES-1:0][VEC_W-1:0] vec;
        logic [N_TYPES-1:0]            sum;
    } store_t;

    store_t st_d, st_q;
    logic   post_ok, clr_ok;

    assign post_ok = post_en && (int'(post_type) < N_TYPES);
    assign clr_ok  = clr_en  && (int'(clr_type)  < N_TYPES);

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.vec = '0;
            st_d.sum = '0;
        end else begin
            if (clr_ok) begin
                st_d.vec[clr_type][clr_idx] = 1'b0;
            end
            // post applied after clear so a same-target post wins
            if (post_ok) begin
                st_d.vec[post_type][post_idx] = 1'b1;
                st_d.sum[post_type]           = 1'b1;
            end
            if (clr_ok && (st_d.vec[clr_type] == '0)) begin
                st_d.sum[clr_type] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_o = st_q.vec;
    assign sum_o = st_q.sum;

    logic [N_TYPES-1:0] nz_chk;
    always_comb begin
        for (int t = 0; t < N_TYPES; t++) nz_chk[t] = |st_q.vec[t];
    end

    // R2
    sum_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sum == nz_chk);

    // R1
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && !clr_all) |=> st_q.vec[$past(post_type)][$past(post_idx)]);

    // R3
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (st_q.sum == '0));

    // R4
    post_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && clr_ok && !clr_all && post_type == clr_type && post_idx == clr_idx)
        |=> st_q.sum[$past(post_type)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_TYPES = NUM_TYPES
) (
    input  logic [N_TYPES-1:0] sum_i,
    input  logic               hpriv,
    input  logic               ie,
    input  logic               tlz_cond,
    output logic               pending_o,
    output logic [TYPE_W-1:0]  win_o
);
    logic [N_TYPES-1:0] elig;

    for (genvar t = 0; t < N_TYPES; t++) begin : g_elig
        logic gate;
        if (t == int'(IT_TLZ)) begin : g_tlz
            assign gate = hpriv ? 1'b0 : tlz_cond;
        end else begin : g_other
            assign gate = hpriv ? (hpriv_allowed(t) && ie)
                                : (ignores_ie(t) || ie);
        end
        assign elig[t] = sum_i[t] && gate;
    end

    // lowest code wins: scan from the bottom of the priority list upward
    always_comb begin
        win_o = IT_NONE;
        for (int t = N_TYPES - 1; t >= 0; t--) begin
            if (elig[t]) win_o = TYPE_W'(t);
        end
    end

    assign pending_o = |elig;
endmodule

// File: rtl/irq_soft_level.sv
module irq_soft_level #(
    parameter int SRC_W = 17,
    parameter int LVL_W = 4,
    localparam int DIRECT_LVL = 14
) (
    input  logic [SRC_W-1:0] src_i,
    output logic [LVL_W-1:0] lvl_o
);
    always_comb begin
        lvl_o = '0;
        if (src_i[0] || src_i[SRC_W-1]) begin
            lvl_o = LVL_W'(DIRECT_LVL);
        end else begin
            for (int b = 1; b < SRC_W - 1; b++) begin
                if (src_i[b]) lvl_o = LVL_W'(b);
            end
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_W = 64,
    parameter int LVL_W = 4,
    localparam int IDX_W  = $clog2(VEC_W),
    localparam int SOFT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_en,
    input  logic [2:0]       post_type,
    input  logic [IDX_W-1:0] post_idx,
    input  logic             clr_en,
    input  logic [2:0]       clr_type,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_all,
    input  logic             hpriv,
    input  logic             ie,
    input  logic             tlz_cond,
    input  logic [2:0]       rd_type,
    output logic             irq_pending,
    output logic [2:0]       irq_type,
    output logic [LVL_W-1:0] soft_level,
    output logic [VEC_W-1:0] rd_vec
);
    logic [NUM_TYPES-1:0][VEC_W-1:0] vec_q;
    logic [NUM_TYPES-1:0]            sum_q;

    irq_vec_store #(.N_TYPES(NUM_TYPES), .VEC_W(VEC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_en   (post_en),
        .post_type (post_type),
        .post_idx  (post_idx),
        .clr_en    (clr_en),
        .clr_type  (clr_type),
        .clr_idx   (clr_idx),
        .clr_all   (clr_all),
        .vec_o     (vec_q),
        .sum_o     (sum_q)
    );

    irq_arbiter #(.N_TYPES(NUM_TYPES)) u_arb (
        .sum_i     (sum_q),
        .hpriv     (hpriv),
        .ie        (ie),
        .tlz_cond  (tlz_cond),
        .pending_o (irq_pending),
        .win_o     (irq_type)
    );

    logic [SOFT_W-1:0] soft_src;
    assign soft_src = vec_q[IT_SOFT][SOFT_W-1:0];

    irq_soft_level #(.SRC_W(SOFT_W), .LVL_W(LVL_W)) u_lvl (
        .src_i (soft_src),
        .lvl_o (soft_level)
    );

    assign rd_vec = (int'(rd_type) < NUM_TYPES) ? vec_q[rd_type] : '0;

    // R5
    idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q == '0) |-> (!irq_pending && irq_type == IT_NONE));

    // R6
    hpriv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hpriv && irq_pending) |-> (ie && (irq_type == IT_TICK || irq_type == IT_IVEC)));

    // R8
    low_no_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hpriv && !ie && irq_pending) |-> (irq_type <= IT_IVEC));

    // R9
    tlz_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_type == IT_TLZ) |-> (tlz_cond && !hpriv));

    // R10
    soft_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_src[0] || soft_src[SOFT_W-1]) |-> (soft_level == LVL_W'(14)));
endmodule

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 0, clr_en = 0, clr_all = 0;
    logic [2:0]  post_type = 0, clr_type = 0, rd_type = 0;
    logic [5:0]  post_idx = 0, clr_idx = 0;
    logic        hpriv = 0, ie = 0, tlz_cond = 0;
    logic        irq_pending;
    logic [2:0]  irq_type;
    logic [3:0]  soft_level;
    logic [63:0] rd_vec;

    int total = 0;
    int bad   = 0;

    logic [63:0] m_vec [7];

    always #4 clk = ~clk;

    irq_pend_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_type(post_type), .post_idx(post_idx),
        .clr_en(clr_en), .clr_type(clr_type), .clr_idx(clr_idx),
        .clr_all(clr_all), .hpriv(hpriv), .ie(ie), .tlz_cond(tlz_cond),
        .rd_type(rd_type), .irq_pending(irq_pending), .irq_type(irq_type),
        .soft_level(soft_level), .rd_vec(rd_vec)
    );

    function automatic int exp_type();
        if (hpriv) begin
            if (ie && m_vec[1] != 0) return 1;
            if (ie && m_vec[2] != 0) return 2;
            return 7;
        end
        if (tlz_cond && m_vec[0] != 0) return 0;
        if (m_vec[1] != 0) return 1;
        if (m_vec[2] != 0) return 2;
        if (!ie) return 7;
        for (int k = 3; k <= 6; k++) if (m_vec[k] != 0) return k;
        return 7;
    endfunction

    function automatic int exp_level();
        logic [63:0] s = m_vec[5];
        if (s[0] || s[16]) return 14;
        for (int b = 15; b >= 1; b--) if (s[b]) return b;
        return 0;
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        int et;
        #1;
        et = exp_type();
        check(tag, "pending", longint'(irq_pending), longint'(et != 7));
        check(tag, "type", longint'(irq_type), longint'(et));
        check(tag, "level", longint'(soft_level), longint'(exp_level()));
        check(tag, "readback", longint'(rd_vec),
              (rd_type < 7) ? longint'(m_vec[rd_type]) : 0);
        @(posedge clk);
        if (rst_n) begin
            if (clr_all) begin
                for (int k = 0; k < 7; k++) m_vec[k] = 0;
            end else begin
                if (clr_en && clr_type < 7) m_vec[clr_type][clr_idx] = 1'b0;
                if (post_en && post_type < 7) m_vec[post_type][post_idx] = 1'b1;
            end
        end
        @(negedge clk);
        post_en = 0; clr_en = 0; clr_all = 0;
    endtask

    task automatic do_post(int t, int i, string tag);
        post_en = 1; post_type = 3'(t); post_idx = 6'(i); rd_type = 3'(t);
        step(tag);
    endtask

    task automatic do_clr(int t, int i, string tag);
        clr_en = 1; clr_type = 3'(t); clr_idx = 6'(i); rd_type = 3'(t);
        step(tag);
    endtask

    task automatic set_mode(bit h, bit e, bit z, string tag);
        hpriv = h; ie = e; tlz_cond = z;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) m_vec[k] = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        step("R12");
        step("R12");

        // R1: posting and readback, plus the unused code 7
        do_post(5, 5, "R1");
        do_post(3, 63, "R1");
        do_post(7, 4, "R1");
        rd_type = 3'd7; step("R1");
        rd_type = 3'd5; step("R10");

        // R10: soft level mapping
        do_post(5, 0, "R10");  step("R10");
        do_clr(5, 0, "R10");   step("R10");
        do_post(5, 16, "R10"); step("R10");
        do_clr(5, 16, "R10");
        do_post(5, 15, "R10"); step("R10");
        do_post(5, 40, "R10");
        do_clr(5, 15, "R10");
        do_clr(5, 5, "R10");   step("R10");

        // R8: enable flag gates the lower classes
        set_mode(0, 0, 0, "R8");
        set_mode(0, 1, 0, "R8");
        set_mode(0, 0, 0, "R8");

        // R7: priority walk in the lower mode
        ie = 1;
        do_post(4, 2, "R7");
        do_post(6, 9, "R7");
        do_clr(3, 63, "R7");
        do_clr(4, 2, "R7");
        do_clr(5, 40, "R7");  step("R7");
        do_post(5, 3, "R7");
        do_post(2, 3, "R7");
        do_post(1, 7, "R7");
        set_mode(0, 0, 0, "R8");

        // R9: trap-level-zero needs the condition input
        do_post(0, 1, "R9");
        set_mode(0, 0, 1, "R9");
        set_mode(0, 0, 0, "R9");

        // R11: mode flips reflected in the same cycle
        set_mode(0, 1, 1, "R11");
        set_mode(1, 1, 1, "R11");
        set_mode(0, 1, 1, "R11");

        // R6: hyperprivileged masking
        set_mode(1, 0, 1, "R6");
        set_mode(1, 1, 1, "R6");
        do_clr(1, 7, "R6");
        do_clr(2, 3, "R6");   step("R6");
        set_mode(1, 0, 0, "R6");

        // R2: summary survives while other bits remain
        hpriv = 0; ie = 1; tlz_cond = 0;
        do_clr(0, 1, "R2");
        do_post(3, 1, "R2");
        do_post(3, 2, "R2");
        do_clr(3, 1, "R2");   step("R2");
        do_clr(3, 2, "R2");   step("R2");
        do_clr(6, 20, "R2");  step("R2");

        // R4: same-target post and clear; clear-all overrides
        post_en = 1; post_type = 3'd4; post_idx = 6'd11;
        clr_en = 1;  clr_type = 3'd4;  clr_idx = 6'd11; rd_type = 3'd4;
        step("R4"); step("R4");
        post_en = 1; post_type = 3'd2; post_idx = 6'd0; clr_all = 1;
        rd_type = 3'd2;
        step("R4"); step("R4");

        // R3 / R5: wipe and idle in every mode
        do_post(1, 33, "R3");
        do_post(6, 0, "R3");
        clr_all = 1; step("R3");
        for (int m = 0; m < 8; m++) begin
            set_mode(m[2], m[1], m[0], "R5");
        end

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            post_en   = ($urandom_range(0, 1) == 1);
            post_type = 3'($urandom_range(0, 7));
            post_idx  = 6'($urandom_range(0, 20));
            clr_en    = ($urandom_range(0, 2) != 0);
            clr_type  = 3'($urandom_range(0, 7));
            clr_idx   = 6'($urandom_range(0, 20));
            clr_all   = ($urandom_range(0, 99) == 0);
            hpriv     = ($urandom_range(0, 3) == 0);
            ie        = ($urandom_range(0, 1) == 1);
            tlz_cond  = ($urandom_range(0, 1) == 1);
            rd_type   = 3'($urandom_range(0, 7));
            step("R7");
        end
        step("R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule